// File: doc/BRIEF.md
# Parallel Port FIFO Controller

This block is the register-level core of a host parallel port. The host reaches it through a byte-wide register bus that uses offsets from the port's base address. The low group holds a data register, a status register and a control register. A second group, 400h above the base, holds a FIFO write port, a fixed identification register and the extended control register. The top three bits of the extended control register choose a submode, and that submode decides who drives the peripheral: software through the data and control registers, or a built-in engine that empties a 16-byte FIFO onto the peripheral data lines.

In the hardware-forward submodes the engine takes one byte at a time from the FIFO. It places the byte on the data lines and holds it there for one clock. It then drives the strobe low for a parameterised number of clocks. It does not start the next byte until the peripheral releases busy. The software submodes hold the FIFO empty and pass the data and control registers straight to the pins. The direction bit in the control register switches the data drivers off so the host can read the peripheral. In two of the submodes this bit is forced to forward.

Top module: `lpt_fifo_port`

## Requirements
- R1: After reset, the extended control register reads 01h, the control register reads 00h, strobeN and pdOutEn are 1 and intOut is 0.
- R2: The extended control register is at offset 402h. Bits 7..2 read back as written, and bits 7..5 select the submode: 000 standard, 001 bidirectional software, 010 hardware forward, 011 hardware with software-set direction.
- R3: Control register (offset 002h) bit 5 is the direction bit, where 1 means reverse. In submodes 000 and 010 it reads 0 and pdOutEn stays 1 whatever value is stored. In submodes 001 and 011 a stored 1 reads back as 1 and drives pdOutEn to 0.
- R4: A read of the data register (offset 000h) returns the last byte written in submode 000. In every other submode it returns the live pdIn lines.
- R5: The register at offset 401h always reads 10h, and writes to it change nothing.
- R6: Bit 1 of the extended control register reads 1 when the 16-byte FIFO is full, and bit 0 reads 1 when it is empty. Writes to these two bits are ignored.
- R7: A write to the FIFO port (offset 400h) while the FIFO is full is dropped. The full flag stays set, and the 16 stored bytes are unchanged and keep their order.
- R8: An extended control register write that selects submode 000 or 001 leaves the FIFO empty from the next cycle. FIFO-port writes made while in those submodes are ignored.
- R9: In submode 010, or in 011 with direction forward, the FIFO bytes appear on pdOut in write order. Each byte stays stable while strobeN is held low for STB_CYC clocks.
- R10: Status register (offset 001h) bit 7 reads the inverse of busyIn. The engine starts no new byte while busyIn is 1, so two strobe pulses are separated by at least the time busy stays high.
- R11: When control bit 4 is 1, a rising edge on ackN sets intOut and status bit 2. A status read clears both unless a new edge arrives in the same cycle. Status bit 6 reads the level of ackN.
- R12: Outside submodes 010 and 011, pdOut carries the data register and strobeN is the inverse of control bit 0.
- R13: In submode 011 with direction reverse, the FIFO is neither drained nor written. Draining resumes once direction returns to forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register offset from the port base |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (side effects on reads) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| pdOut | output | 8 | Peripheral data lines, output value |
| pdIn | input | 8 | Peripheral data lines, sensed value |
| pdOutEn | output | 1 | Data driver enable, 1 = forward |
| strobeN | output | 1 | Active-low data strobe |
| busyIn | input | 1 | Peripheral busy, active high |
| ackN | input | 1 | Active-low peripheral acknowledge |
| intOut | output | 1 | Port interrupt request |

## Verification
The drain engine is tested with three patterns. A short burst against a peripheral that holds busy after each strobe shows whether the engine waits for busy. An overfilled FIFO released all at once shows whether writes past the full point are dropped, and whether order and pulse width are kept. A FIFO filled in one submode and then switched away shows whether a submode change flushes it. Register behaviour is checked in each submode: the readback of the data register tells the latched value apart from the live lines, and the direction bit is set in a forced submode and in a free one. The interrupt is driven with an acknowledge edge while enabled and while disabled, to show the enable gating and the clear on a status read.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam logic [2:0] SUB_STD = 3'b000;
  localparam logic [2:0] SUB_BIDIR = 3'b001;
  localparam logic [2:0] SUB_HWFWD = 3'b010;
  localparam logic [2:0] SUB_HWDIR = 3'b011;

  localparam logic [7:0] CFGA_VALUE = 8'h10;

  typedef enum logic [1:0] {
    DRV_IDLE  = 2'd0,
    DRV_SETUP = 2'd1,
    DRV_PULSE = 2'd2
  } drvState_t;

  typedef struct packed {
    logic wrData;
    logic wrCtrl;
    logic wrEcr;
    logic push;
    logic pop;
    logic flush;
  } lptStrobe_t;

endpackage

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lptStrobe_t        st,
  input  logic [7:0]        wrByte,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        pdIn,
  input  logic              busyIn,
  input  logic              ackN,
  input  logic              irqPend,
  output logic [7:0]        rdData,
  output logic [7:0]        pdOut,
  output logic              pdOutEn,
  output logic [2:0]        mode,
  output logic              effDir,
  output logic              ackIntEn,
  output logic              swStrobe,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h001);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] OFS_CFGA = ADDR_W'(12'h401);
  localparam logic [ADDR_W-1:0] OFS_ECR = ADDR_W'(12'h402);

  logic [7:0] dataReg;
  logic [5:0] ctrlReg;
  logic [5:0] ecrReg;
  logic [7:0] outByte;
  logic [7:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop, hwMode;

  assign mode = ecrReg[5:3];
  assign hwMode = (mode == SUB_HWFWD) || (mode == SUB_HWDIR);
  assign effDir = ((mode == SUB_STD) || (mode == SUB_HWFWD)) ? 1'b0 : ctrlReg[5];
  assign ackIntEn = ctrlReg[4];
  assign swStrobe = ctrlReg[0];
  assign full = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign doPush = st.push && !full;
  assign doPop = st.pop && !empty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
      ecrReg <= '0;
    end else begin
      if (st.wrData) dataReg <= wrByte;
      if (st.wrCtrl) ctrlReg <= wrByte[5:0];
      if (st.wrEcr) ecrReg <= wrByte[7:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outByte <= '0;
    else if (doPop) outByte <= mem[rdPtr];
  end

  assign pdOut = hwMode ? outByte : dataReg;
  assign pdOutEn = !effDir;

  always_comb begin
    unique case (rdAddr)
      OFS_DATA: rdData = (mode == SUB_STD) ? dataReg : pdIn;
      OFS_STAT: rdData = {!busyIn, ackN, 3'b000, irqPend, 2'b00};
      OFS_CTRL: rdData = {2'b00, effDir, ctrlReg[4:0]};
      OFS_CFGA: rdData = CFGA_VALUE;
      OFS_ECR:  rdData = {ecrReg, full, empty};
      default:  rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/lpt_control.sv
module lpt_control
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int STB_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  input  logic [2:0]        mode,
  input  logic              effDir,
  input  logic              ackIntEn,
  input  logic              swStrobe,
  input  logic              empty,
  input  logic              busyIn,
  input  logic              ackN,
  output lptStrobe_t        st,
  output logic              strobeN,
  output logic              irqPend
);
  localparam int CW = $clog2(STB_CYC + 1);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h001);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] OFS_FIFO = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_ECR = ADDR_W'(12'h402);

  drvState_t state;
  logic [CW-1:0] pulseCnt;
  logic ackPrev, ackRise, statRd, swMode, hwMode, drainOk;

  assign swMode = (mode == SUB_STD) || (mode == SUB_BIDIR);
  assign hwMode = (mode == SUB_HWFWD) || (mode == SUB_HWDIR);
  assign drainOk = (mode == SUB_HWFWD) || ((mode == SUB_HWDIR) && !effDir);

  always_comb begin
    st.wrData = busWrEn && (busAddr == OFS_DATA);
    st.wrCtrl = busWrEn && (busAddr == OFS_CTRL);
    st.wrEcr = busWrEn && (busAddr == OFS_ECR);
    st.push = busWrEn && (busAddr == OFS_FIFO) && drainOk;
    st.pop = (state == DRV_IDLE) && drainOk && !empty && !busyIn;
    st.flush = swMode || (st.wrEcr && (busWrData[7:6] == 2'b00));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !drainOk) begin
      state <= DRV_IDLE;
      pulseCnt <= '0;
    end else begin
      unique case (state)
        DRV_IDLE: if (st.pop) state <= DRV_SETUP;
        DRV_SETUP: begin
          state <= DRV_PULSE;
          pulseCnt <= '0;
        end
        DRV_PULSE: begin
          pulseCnt <= pulseCnt + 1'b1;
          if (pulseCnt == CW'(STB_CYC - 1)) state <= DRV_IDLE;
        end
        default: state <= DRV_IDLE;
      endcase
    end
  end

  assign strobeN = hwMode ? (state != DRV_PULSE) : !swStrobe;

  assign ackRise = ackN && !ackPrev;
  assign statRd = busRdEn && (busAddr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackPrev <= 1'b1;
      irqPend <= 1'b0;
    end else begin
      ackPrev <= ackN;
      if (ackRise && ackIntEn) irqPend <= 1'b1;
      else if (statRd) irqPend <= 1'b0;
    end
  end

endmodule

// File: rtl/lpt_fifo_port.sv
module lpt_fifo_port
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH = 16,
  parameter int STB_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [7:0]        pdOut,
  input  logic [7:0]        pdIn,
  output logic              pdOutEn,
  output logic              strobeN,
  input  logic              busyIn,
  input  logic              ackN,
  output logic              intOut
);
  lptStrobe_t stW;
  logic [2:0] modeW;
  logic effDirW, ackIntEnW, swStrobeW, fullW, emptyW, irqW;

  lpt_control #(.ADDR_W(ADDR_W), .STB_CYC(STB_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .mode(modeW), .effDir(effDirW),
    .ackIntEn(ackIntEnW), .swStrobe(swStrobeW), .empty(emptyW),
    .busyIn(busyIn), .ackN(ackN), .st(stW), .strobeN(strobeN), .irqPend(irqW)
  );

  lpt_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(stW), .wrByte(busWrData), .rdAddr(busAddr),
    .pdIn(pdIn), .busyIn(busyIn), .ackN(ackN), .irqPend(irqW),
    .rdData(busRdData), .pdOut(pdOut), .pdOutEn(pdOutEn), .mode(modeW),
    .effDir(effDirW), .ackIntEn(ackIntEnW), .swStrobe(swStrobeW),
    .full(fullW), .empty(emptyW)
  );

  assign intOut = irqW;

endmodule

// File: rtl/lpt_port_checker.sv
module lpt_port_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [7:0]        busWrData,
  input logic [7:0]        busRdData,
  input logic              pdOutEn,
  input logic              ackN,
  input logic              intOut,
  input logic [2:0]        modeW,
  input logic              fullW,
  input logic              emptyW,
  input logic              popW
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h001);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'(12'h401);
  localparam logic [ADDR_W-1:0] A_ECR = ADDR_W'(12'h402);

  AST_ECR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_ECR) |-> (busRdData[1:0] == {fullW, emptyW})); // R6

  AST_DIR_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (modeW == 3'b000 || modeW == 3'b010) |-> pdOutEn); // R3

  AST_CFGA_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_CFGA) |-> (busRdData == 8'h10)); // R5

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fullW && busWrEn && busAddr == A_FIFO && !popW && modeW[2:1] == 2'b01) |=> fullW); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ECR && busWrData[7:6] == 2'b00) |=> emptyW); // R8

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_STAT && !$rose(ackN)) |=> !intOut); // R11

endmodule

bind lpt_fifo_port lpt_port_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
  .pdOutEn(pdOutEn), .ackN(ackN), .intOut(intOut), .modeW(modeW),
  .fullW(fullW), .emptyW(emptyW), .popW(stW.pop)
);

// File: tb/lpt_fifo_port_test.sv
module lpt_fifo_port_test;
  localparam int STB = 4;
  localparam int BUSY_HOLD = 8;
  localparam logic [10:0] A_DATA = 11'h000;
  localparam logic [10:0] A_STAT = 11'h001;
  localparam logic [10:0] A_CTRL = 11'h002;
  localparam logic [10:0] A_FIFO = 11'h400;
  localparam logic [10:0] A_CFGA = 11'h401;
  localparam logic [10:0] A_ECR = 11'h402;

  logic clk = 0, rstN = 0;
  logic [10:0] busAddr = '0;
  logic busWrEn = 0, busRdEn = 0;
  logic [7:0] busWrData = '0, busRdData, pdOut, pdIn = '0;
  logic pdOutEn, strobeN, intOut;
  logic busyIn = 0, ackN = 1;

  int checks = 0, errors = 0;
  bit done = 0;

  bit busyForce = 0;
  int busyCnt = 0, curW = 0, capCnt = 0, widthErr = 0, dataErr = 0, busyViol = 0;
  int cyc = 0, lastFall = -1, minGap = 1000000;
  logic [7:0] capByte = '0;
  logic [7:0] capBuf [32];
  logic prevStb = 1;

  lpt_fifo_port #(.ADDR_W(11), .DEPTH(16), .STB_CYC(STB)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pdOut(pdOut), .pdIn(pdIn), .pdOutEn(pdOutEn), .strobeN(strobeN),
    .busyIn(busyIn), .ackN(ackN), .intOut(intOut)
  );

  always #2 clk = ~clk;

  // peripheral model: captures strobed bytes and holds busy after each
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prevStb && !strobeN) begin
        if (busyIn) busyViol++;
        capByte = pdOut;
        curW = 0;
        if (lastFall >= 0 && (cyc - lastFall) < minGap) minGap = cyc - lastFall;
        lastFall = cyc;
      end
      if (!strobeN) begin
        curW++;
        if (pdOut !== capByte) dataErr++;
      end
      if (!prevStb && strobeN) begin
        if (capCnt < 32) capBuf[capCnt] = capByte;
        capCnt++;
        if (curW != STB) widthErr++;
        busyCnt = BUSY_HOLD;
      end else if (busyCnt > 0) busyCnt--;
      busyIn = busyForce || (busyCnt > 0);
      prevStb = strobeN;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    capCnt = 0; widthErr = 0; dataErr = 0; busyViol = 0;
    lastFall = -1; minGap = 1000000;
  endtask

  task automatic busWrite(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic busRead(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(A_ECR, d);  check("R1", d, 8'h01, "ecr after reset");
    busRead(A_CTRL, d); check("R1", d, 8'h00, "ctrl after reset");
    check("R1", strobeN, 1, "strobeN after reset");
    check("R1", pdOutEn, 1, "pdOutEn after reset");
    check("R1", intOut, 0, "intOut after reset");
  endtask

  task automatic testEcrFields();
    logic [7:0] d;
    busWrite(A_ECR, 8'h9F);
    busRead(A_ECR, d); check("R2", d, 8'h9D, "ecr readback with flag bits written");
    busWrite(A_ECR, 8'h00);
    busRead(A_ECR, d); check("R6", d, 8'h01, "empty flag in std mode");
  endtask

  task automatic testDirection();
    logic [7:0] d;
    busWrite(A_ECR, 8'h00);
    busWrite(A_CTRL, 8'h20);
    busRead(A_CTRL, d); check("R3", d, 8'h00, "dir forced in 000");
    check("R3", pdOutEn, 1, "pdOutEn in 000");
    busWrite(A_ECR, 8'h20);
    busRead(A_CTRL, d); check("R3", d, 8'h20, "dir free in 001");
    check("R3", pdOutEn, 0, "pdOutEn reverse in 001");
    busWrite(A_ECR, 8'h40);
    busRead(A_CTRL, d); check("R3", d, 8'h00, "dir forced in 010");
    check("R3", pdOutEn, 1, "pdOutEn in 010");
    busWrite(A_ECR, 8'h00);
    busWrite(A_CTRL, 8'h00);
  endtask

  task automatic testSoftware();
    logic [7:0] d;
    busWrite(A_ECR, 8'h00);
    pdIn = 8'h3C;
    busWrite(A_DATA, 8'hA5);
    busRead(A_DATA, d); check("R4", d, 8'hA5, "data readback in 000");
    check("R12", pdOut, 8'hA5, "pdOut follows data reg");
    busWrite(A_CTRL, 8'h01);
    check("R12", strobeN, 0, "software strobe asserted");
    busWrite(A_CTRL, 8'h00);
    check("R12", strobeN, 1, "software strobe released");
    busWrite(A_ECR, 8'h20);
    busRead(A_DATA, d); check("R4", d, 8'h3C, "live lines in 001");
    busWrite(A_ECR, 8'h00);
  endtask

  task automatic testConfigA();
    logic [7:0] d;
    busWrite(A_CFGA, 8'h5A);
    busRead(A_CFGA, d); check("R5", d, 8'h10, "config A constant after write");
    busRead(A_ECR, d); check("R5", d, 8'h01, "config A write leaves ecr unchanged");
  endtask

  task automatic testFlush();
    logic [7:0] d;
    busyForce = 1; idle(2);
    busWrite(A_ECR, 8'h40);
    for (int i = 0; i < 3; i++) busWrite(A_FIFO, 8'h70 + 8'(i));
    busRead(A_ECR, d); check("R6", d, 8'h40, "not empty after 3 pushes");
    busWrite(A_ECR, 8'h20);
    busRead(A_ECR, d); check("R8", d, 8'h21, "empty after selecting 001");
    busWrite(A_FIFO, 8'h77);
    busRead(A_ECR, d); check("R8", d, 8'h21, "fifo write ignored in 001");
    clearMon();
    busWrite(A_ECR, 8'h40);
    busyForce = 0;
    idle(60);
    check("R8", capCnt, 0, "nothing left to drain after flush");
    busWrite(A_ECR, 8'h00);
  endtask

  task automatic testFullDrop();
    logic [7:0] d;
    bit orderOk = 1;
    busyForce = 1; idle(2);
    busWrite(A_ECR, 8'h40);
    for (int i = 0; i < 18; i++) busWrite(A_FIFO, 8'h30 + 8'(i));
    busRead(A_ECR, d); check("R6", d, 8'h42, "full flag after overfill");
    clearMon();
    busyForce = 0;
    idle(16 * (STB + BUSY_HOLD + 4) + 40);
    check("R7", capCnt, 16, "bytes drained after overfill");
    for (int i = 0; i < 16; i++) if (capBuf[i] != 8'h30 + 8'(i)) orderOk = 0;
    check("R7", orderOk, 1, "stored bytes kept in order");
    check("R9", widthErr, 0, "strobe width errors");
    check("R9", dataErr, 0, "data changed during strobe");
    busRead(A_ECR, d); check("R6", d, 8'h41, "empty after drain");
    busWrite(A_ECR, 8'h00);
  endtask

  task automatic testDrainBusy();
    logic [7:0] d;
    clearMon();
    busWrite(A_ECR, 8'h40);
    for (int i = 0; i < 5; i++) busWrite(A_FIFO, 8'hC0 + 8'(i));
    idle(5 * (STB + BUSY_HOLD + 4) + 40);
    check("R9", capCnt, 5, "burst byte count");
    check("R9", capBuf[0], 8'hC0, "first byte");
    check("R9", capBuf[4], 8'hC4, "last byte");
    check("R10", busyViol, 0, "strobe while busy");
    check("R10", (minGap >= STB + BUSY_HOLD) ? 1 : 0, 1, "gap covers busy time");
    busyForce = 1; idle(2);
    busRead(A_STAT, d); check("R10", d[7], 0, "status bit7 while busy");
    busyForce = 0; idle(2);
    busRead(A_STAT, d); check("R10", d[7], 1, "status bit7 while idle");
    busWrite(A_ECR, 8'h00);
  endtask

  task automatic testReverse();
    clearMon();
    busyForce = 1; idle(2);
    busWrite(A_ECR, 8'h60);
    busWrite(A_CTRL, 8'h00);
    busWrite(A_FIFO, 8'h11);
    busWrite(A_FIFO, 8'h22);
    busWrite(A_CTRL, 8'h20);
    check("R13", pdOutEn, 0, "drivers off in 011 reverse");
    busWrite(A_FIFO, 8'h33);
    busyForce = 0;
    idle(60);
    check("R13", capCnt, 0, "no drain while reverse");
    busWrite(A_CTRL, 8'h00);
    idle(3 * (STB + BUSY_HOLD + 4) + 20);
    check("R13", capCnt, 2, "drain resumes, reverse write dropped");
    check("R13", capBuf[1], 8'h22, "second byte after resume");
    busWrite(A_ECR, 8'h00);
  endtask

  task automatic pulseAck();
    @(negedge clk); ackN = 0;
    idle(2);
    ackN = 1;
    idle(2);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    busWrite(A_ECR, 8'h20);
    busWrite(A_CTRL, 8'h10);
    pulseAck();
    check("R11", intOut, 1, "irq on ack rise");
    busRead(A_STAT, d); check("R11", d, 8'hC4, "status with pending irq");
    check("R11", intOut, 0, "irq cleared by status read");
    busWrite(A_CTRL, 8'h00);
    pulseAck();
    check("R11", intOut, 0, "no irq when disabled");
    @(negedge clk); ackN = 0;
    busRead(A_STAT, d); check("R11", d[6], 0, "status bit6 follows ackN low");
    ackN = 1;
    busWrite(A_ECR, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    rstN = 1;
    idle(2);
    testReset();
    testEcrFields();
    testDirection();
    testSoftware();
    testConfigA();
    testFlush();
    testFullDrop();
    testDrainBusy();
    testReverse();
    testIrq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule